// File: doc/BRIEF.md
# Multi-Channel Reloading Timer Unit

The block gathers two or three down-counting timer channels behind a single register window. A shared start register holds one run bit per channel. An optional one-bit output-control register drives a pin. An address decoder routes each access to a channel at that channel's local word offset. Each channel counts down at a rate chosen from a shared prescaler or from an external tick. When the count reaches zero it reloads and raises an underflow flag. That flag, gated by the channel's interrupt enable, drives that channel's own interrupt pin.

A build parameter sets the number of channels. When a third channel is built it is the only one with a capture register, which latches the live count on a capture pulse. Two more parameters select whether the output-control register exists and whether the external-tick rates are legal. The access port is a plain request/write/address/data interface. It has no back-pressure: every request completes in the cycle it is presented, and read data and the error pulse are valid in that same cycle.

Top module: `tmr_unit`

## Requirements
- R1: After reset the start register and output-control bit are 0, every channel's reload and count registers hold all ones, every control register reads 0 and all interrupt pins are low.
- R2: The word map is as follows. 0x00 is output control and 0x04 is start. Channel 0 has reload at 0x08, count at 0x0C and control at 0x10. Channel 1 uses 0x14, 0x18 and 0x1C. Channel 2 uses 0x20, 0x24 and 0x28, with its capture register at 0x2C. The two low address bits are ignored, and read data appears in the cycle of the request.
- R3: Start bit i (bit 0, 1, 2) runs channel i. The start register reads back its bits, and bits at or above the channel count read 0.
- R4: On each selected tick a running channel's count drops by one. A tick at count 0 loads the reload value and sets the underflow flag (control bit 4) on the following edge.
- R5: Control bits [2:0] select the rate. Codes 0 to 4 tick once every 4, 16, 64, 256 and 1024 cycles. The tick comes from a shared divider that starts at 0 on reset release and fires when its low 2k+2 bits are all ones. Codes 5 to 7 take `ext_tick_i` when external ticks are enabled.
- R6: `irq_o[i]` is high exactly while channel i has its underflow flag set and its enable (control bit 3) set.
- R7: A control write stores rate and enable. It clears the underflow flag when bit 4 is 0 and leaves it when bit 4 is 1, and a new underflow in the same cycle wins. A count write in the same cycle as a tick wins over the tick.
- R8: A channel whose start bit is 0 holds its count.
- R9: On `cap_pulse_i`, channel 2 copies its present count into the capture register and sets control bit 5. Writing bit 5 as 0 clears it. Writes to the capture register have no effect.
- R10: The output-control register keeps bit 0 of the last write to 0x00 and drives `out_ctrl_o`.
- R11: These accesses are invalid: an unmapped word; 0x00 without output control; 0x20 and up with two channels; a start write with bit 2 set in a two-channel build; a control write with rate 5 to 7 without external ticks. They read 0, change nothing, and raise `err_o` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset in the window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, same cycle |
| err_o | output | 1 | Invalid access this cycle |
| ext_tick_i | input | 1 | External count tick, one-cycle pulse |
| cap_pulse_i | input | 1 | Capture strobe for channel 2 |
| irq_o | output | NUM_CH | Per-channel interrupt |
| out_ctrl_o | output | 1 | Output-control bit |

## Verification
The assertions assume that `addr_i`, `we_i` and `wdata_i` are known whenever `req_i` is high. They also assume that `ext_tick_i` and `cap_pulse_i` are synchronous pulses, and that at most one access arrives per cycle. The stimulus changes every input only on the falling clock edge. Each access and each strobe is held for exactly one cycle. The divider phase the bench relies on is fixed by releasing reset between edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int NUM_RATES = 5;
  localparam int RATE_W    = 3;
  localparam int CTL_IE    = 3;
  localparam int CTL_UF    = 4;
  localparam int CTL_CF    = 5;
  localparam int LOC_RELOAD = 0;
  localparam int LOC_COUNT  = 1;
  localparam int LOC_CTRL   = 2;
  localparam int LOC_CAPT   = 3;
  localparam int CAP_CHAN   = 2;
  localparam int START_W    = 3;

  typedef enum logic [1:0] {TGT_NONE, TGT_OUTCTL, TGT_START, TGT_CHAN} tgt_e;

  function automatic int chan_base_word(input int idx);
    return 2 + 3 * idx;
  endfunction

  function automatic int chan_span(input int idx);
    return (idx == CAP_CHAN) ? 4 : 3;
  endfunction
endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
  import tmr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_CH     = 3,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output tgt_e              tgt_o,
  output logic [NUM_CH-1:0] ch_sel_o,
  output logic [1:0]        loc_o
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        loc_ch [NUM_CH];

  assign word = addr_i[ADDR_W-1:2];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    localparam int BASE = chan_base_word(i);
    localparam int SPAN = chan_span(i);
    assign ch_sel_o[i] = (int'(word) >= BASE) && (int'(word) < BASE + SPAN);
    assign loc_ch[i]   = 2'(int'(word) - BASE);
  end

  always_comb begin
    loc_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel_o[i]) loc_o = loc_ch[i];
    end
  end

  always_comb begin
    tgt_o = TGT_NONE;
    if (word == '0) begin
      if (HAS_OUTCTL) tgt_o = TGT_OUTCTL;
    end else if (word == WORD_W'(1)) begin
      tgt_o = TGT_START;
    end else if (|ch_sel_o) begin
      tgt_o = TGT_CHAN;
    end
  end

  always_comb begin
    if (!$isunknown(addr_i)) begin
      AST_ONE_TARGET: assert ($onehot0(ch_sel_o)); // R2
    end
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int NR = NUM_RATES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [NR-1:0] tick_o
);
  localparam int PRE_W = 2 * NR;

  logic [PRE_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + PRE_W'(1);
  end

  for (genvar k = 0; k < NR; k++) begin : g_tick
    assign tick_o[k] = &div_q[2*k+1:0];
  end

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[0] |=> !tick_o[0]); // R5
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit HAS_CAP = 1'b0,
  parameter bit HAS_EXT = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [NUM_RATES-1:0] rate_tick_i,
  input  logic                 ext_tick_i,
  input  logic                 cap_pulse_i,
  input  logic                 wr_i,
  input  logic [1:0]           loc_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 bad_wdata_o,
  output logic                 irq_o
);
  logic [DATA_W-1:0] rel_q, cnt_q, cap_q;
  logic [RATE_W-1:0] rate_q;
  logic              ie_q, uf_q, cf_q;

  logic wr_rel, wr_cnt, wr_ctl_req, wr_ctl, rate_ok;
  logic tick, step, wrap;
  logic [RATE_W-1:0] rate_new;

  assign wr_rel     = wr_i && (loc_i == 2'(LOC_RELOAD));
  assign wr_cnt     = wr_i && (loc_i == 2'(LOC_COUNT));
  assign wr_ctl_req = wr_i && (loc_i == 2'(LOC_CTRL));
  assign rate_new   = wdata_i[RATE_W-1:0];
  assign rate_ok    = (int'(rate_new) < NUM_RATES) || HAS_EXT;
  assign wr_ctl     = wr_ctl_req && rate_ok;
  assign bad_wdata_o = wr_ctl_req && !rate_ok;

  always_comb begin
    tick = HAS_EXT && ext_tick_i;
    for (int k = 0; k < NUM_RATES; k++) begin
      if (rate_q == RATE_W'(k)) tick = rate_tick_i[k];
    end
  end

  assign step = run_i && tick;
  assign wrap = step && !wr_cnt && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q  <= '1;
      cnt_q  <= '1;
      rate_q <= '0;
      ie_q   <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      if (wr_rel) rel_q <= wdata_i;
      if (wr_cnt)    cnt_q <= wdata_i;
      else if (wrap) cnt_q <= rel_q;
      else if (step) cnt_q <= cnt_q - DATA_W'(1);
      if (wr_ctl) begin
        rate_q <= rate_new;
        ie_q   <= wdata_i[CTL_IE];
      end
      uf_q <= (uf_q && !(wr_ctl && !wdata_i[CTL_UF])) || wrap;
    end
  end

  if (HAS_CAP) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cap_q <= '0;
        cf_q  <= 1'b0;
      end else begin
        if (cap_pulse_i) cap_q <= cnt_q;
        cf_q <= (cf_q && !(wr_ctl && !wdata_i[CTL_CF])) || cap_pulse_i;
      end
    end
  end else begin : g_nocap
    logic unused_cap;
    assign unused_cap = cap_pulse_i;
    assign cap_q = '0;
    assign cf_q  = 1'b0;
  end

  always_comb begin
    case (loc_i)
      2'(LOC_RELOAD): rdata_o = rel_q;
      2'(LOC_COUNT):  rdata_o = cnt_q;
      2'(LOC_CTRL):   rdata_o = DATA_W'({cf_q, uf_q, ie_q, rate_q});
      default:        rdata_o = cap_q;
    endcase
  end

  assign irq_o = uf_q && ie_q;

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_i) |=> $stable(cnt_q)); // R8
  AST_WRAP_RELOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && !wr_i && cnt_q == '0) |=> (uf_q && cnt_q == $past(rel_q))); // R4
  AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && !wr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DATA_W'(1))); // R4
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int NUM_CH     = 3,
  parameter bit HAS_OUTCTL = 1'b1,
  parameter bit HAS_EXT    = 1'b1,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  input  logic              ext_tick_i,
  input  logic              cap_pulse_i,
  output logic [NUM_CH-1:0] irq_o,
  output logic              out_ctrl_o
);
  localparam logic [START_W-1:0] START_LEGAL = START_W'((1 << NUM_CH) - 1);

  tgt_e                 tgt;
  logic [NUM_CH-1:0]    ch_sel, ch_bad, start_q;
  logic [1:0]           loc;
  logic [NUM_RATES-1:0] rate_tick;
  logic [DATA_W-1:0]    ch_rdata [NUM_CH];
  logic                 wr_any, rd_any, start_bad, wr_start, oc_q;

  assign wr_any    = req_i && we_i;
  assign rd_any    = req_i && !we_i;
  assign start_bad = |(wdata_i[START_W-1:0] & ~START_LEGAL);
  assign wr_start  = wr_any && (tgt == TGT_START) && !start_bad;

  tmr_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .HAS_OUTCTL(HAS_OUTCTL)
  ) u_dec (
    .addr_i(addr_i), .tgt_o(tgt), .ch_sel_o(ch_sel), .loc_o(loc)
  );

  tmr_prescaler #(.NR(NUM_RATES)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(rate_tick)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_channel #(
      .DATA_W(DATA_W), .HAS_CAP(i == CAP_CHAN), .HAS_EXT(HAS_EXT)
    ) u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(start_q[i]),
      .rate_tick_i(rate_tick), .ext_tick_i(ext_tick_i), .cap_pulse_i(cap_pulse_i),
      .wr_i(wr_any && ch_sel[i]), .loc_i(loc), .wdata_i(wdata_i),
      .rdata_o(ch_rdata[i]), .bad_wdata_o(ch_bad[i]), .irq_o(irq_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       start_q <= '0;
    else if (wr_start) start_q <= wdata_i[NUM_CH-1:0];
  end

  if (HAS_OUTCTL) begin : g_oc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) oc_q <= 1'b0;
      else if (wr_any && tgt == TGT_OUTCTL) oc_q <= wdata_i[0];
    end
  end else begin : g_nooc
    assign oc_q = 1'b0;
  end

  assign out_ctrl_o = oc_q;

  always_comb begin
    rdata_o = '0;
    if (rd_any) begin
      case (tgt)
        TGT_OUTCTL: rdata_o = DATA_W'(oc_q);
        TGT_START:  rdata_o = DATA_W'(start_q);
        TGT_CHAN: begin
          for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) rdata_o = ch_rdata[i];
          end
        end
        default: rdata_o = '0;
      endcase
    end
  end

  assign err_o = req_i && ((tgt == TGT_NONE) ||
                           (we_i && tgt == TGT_START && start_bad) ||
                           (|ch_bad));

  AST_BAD_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && we_i) |=> ($stable(start_q) && $stable(oc_q))); // R11
  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0)); // R11
endmodule

// File: tb/tb_tmr_unit.sv
`timescale 1ns/1ps
module tb_tmr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 0, we = 0, ext_tick = 0, cap_pulse = 0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err, out_ctrl;
  logic [2:0]  irq;

  logic        b2_req = 0, b2_we = 0;
  logic [7:0]  b2_addr = '0;
  logic [31:0] b2_wdata = '0, b2_rdata, b2_erd;
  logic        b2_err, b2_oc, b2_eerr;
  logic [1:0]  b2_irq;
  bit          b2_chk = 0;
  string       b2_tag = "";

  int total = 0, bad = 0, cyc = 0, rot = 0;
  bit done = 0;
  string phase_tag = "";

  logic [31:0] m_rel [3], m_cnt [3], m_cap;
  int          m_rate [3];
  bit          m_ie [3], m_uf [3], m_cf, m_oc;
  bit [2:0]    m_start;
  int          pre;

  always #4 clk = ~clk;

  tmr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .ext_tick_i(ext_tick),
    .cap_pulse_i(cap_pulse), .irq_o(irq), .out_ctrl_o(out_ctrl)
  );

  tmr_unit #(.NUM_CH(2), .HAS_OUTCTL(1'b0), .HAS_EXT(1'b0)) dut2 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(b2_req), .we_i(b2_we), .addr_i(b2_addr),
    .wdata_i(b2_wdata), .rdata_o(b2_rdata), .err_o(b2_err), .ext_tick_i(1'b0),
    .cap_pulse_i(1'b0), .irq_o(b2_irq), .out_ctrl_o(b2_oc)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int decode(input logic [7:0] a, output int ch, output int loc);
    int w;
    w = int'(a) >> 2;
    ch = 0; loc = 0;
    if (w == 0) return 1;
    if (w == 1) return 2;
    if (w >= 2 && w <= 4)  begin ch = 0; loc = w - 2; return 3; end
    if (w >= 5 && w <= 7)  begin ch = 1; loc = w - 5; return 3; end
    if (w >= 8 && w <= 11) begin ch = 2; loc = w - 8; return 3; end
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_rel[i] = '1; m_cnt[i] = '1; m_rate[i] = 0; m_ie[i] = 0; m_uf[i] = 0;
    end
    m_cap = '0; m_cf = 0; m_oc = 0; m_start = '0; pre = 0;
  endtask

  task automatic expect_out(output logic [31:0] erd, output logic eerr, output string tag);
    int kind, ch, loc;
    logic [31:0] v;
    kind = decode(addr, ch, loc);
    v = '0;
    tag = "R11";
    case (kind)
      1: begin v = {31'b0, m_oc}; tag = "R10"; end
      2: begin v = {29'b0, m_start}; tag = "R3"; end
      3: begin
        case (loc)
          0: begin v = m_rel[ch]; tag = "R2"; end
          1: begin v = m_cnt[ch]; tag = "R4"; end
          2: begin
            v = m_rate[ch] | (int'(m_ie[ch]) << 3) | (int'(m_uf[ch]) << 4);
            if (ch == 2) v = v | (int'(m_cf) << 5);
            tag = "R7";
          end
          default: begin v = m_cap; tag = "R9"; end
        endcase
      end
      default: v = '0;
    endcase
    eerr = req && (kind == 0);
    erd  = (req && !we && kind != 0) ? v : '0;
    if (phase_tag != "") tag = phase_tag;
  endtask

  task automatic model_step();
    bit tk [5];
    int kind, ch, loc, d;
    bit tick, step, wsel, wcnt, wctl, wrel, wrap;
    for (int k = 0; k < 5; k++) begin
      d = 4 << (2 * k);
      tk[k] = ((pre % d) == d - 1);
    end
    kind = decode(addr, ch, loc);
    for (int i = 0; i < 3; i++) begin
      tick = (m_rate[i] < 5) ? tk[m_rate[i]] : ext_tick;
      step = m_start[i] && tick;
      wsel = req && we && kind == 3 && ch == i;
      wrel = wsel && loc == 0;
      wcnt = wsel && loc == 1;
      wctl = wsel && loc == 2;
      wrap = step && !wcnt && m_cnt[i] == 0;
      if (i == 2) begin
        if (cap_pulse) m_cap = m_cnt[2];
        m_cf = (m_cf && !(wctl && !wdata[5])) || cap_pulse;
      end
      if (wcnt)      m_cnt[i] = wdata;
      else if (wrap) m_cnt[i] = m_rel[i];
      else if (step) m_cnt[i] = m_cnt[i] - 1;
      m_uf[i] = (m_uf[i] && !(wctl && !wdata[4])) || wrap;
      if (wctl) begin m_rate[i] = int'(wdata[2:0]); m_ie[i] = wdata[3]; end
      if (wrel) m_rel[i] = wdata;
    end
    if (req && we && kind == 2) m_start = wdata[2:0];
    if (req && we && kind == 1) m_oc = wdata[0];
    pre = (pre + 1) % 1024;
  endtask

  task automatic cycle(input logic r, input logic w, input logic [7:0] a,
                       input logic [31:0] dv, input logic e, input logic c);
    logic [31:0] erd;
    logic eerr;
    string tag;
    req = r; we = w; addr = a; wdata = dv; ext_tick = e; cap_pulse = c;
    #1;
    expect_out(erd, eerr, tag);
    chk(tag, rdata, erd);
    chk("R11", {31'b0, err}, {31'b0, eerr});
    chk("R6", {29'b0, irq}, {29'b0, m_uf[2] & m_ie[2], m_uf[1] & m_ie[1], m_uf[0] & m_ie[0]});
    chk("R10", {31'b0, out_ctrl}, {31'b0, m_oc});
    if (b2_chk) begin
      chk(b2_tag, b2_rdata, b2_erd);
      chk(b2_tag, {31'b0, b2_err}, {31'b0, b2_eerr});
    end
    @(posedge clk);
    model_step();
    @(negedge clk);
    req = 0; we = 0; ext_tick = 0; cap_pulse = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] dv);
    cycle(1, 1, a, dv, 0, 0);
  endtask

  task automatic run_idle(input int n);
    for (int k = 0; k < n; k++) begin
      cycle(1, 0, 8'((rot % 12) * 4), '0, 0, 0);
      rot++;
    end
  endtask

  task automatic two(input logic w, input logic [7:0] a, input logic [31:0] dv,
                     input logic eerr, input logic [31:0] erd, input string tag);
    b2_req = 1; b2_we = w; b2_addr = a; b2_wdata = dv;
    b2_eerr = eerr; b2_erd = erd; b2_tag = tag; b2_chk = 1;
    cycle(1, 0, 8'h04, '0, 0, 0);
    b2_chk = 0; b2_req = 0; b2_we = 0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    phase_tag = "R1";
    run_idle(12);
    phase_tag = "";

    wr(8'h08, 32'd3); wr(8'h0C, 32'd3); wr(8'h10, 32'h8);
    wr(8'h14, 32'd1); wr(8'h18, 32'd1); wr(8'h1C, 32'h9);
    wr(8'h05, 32'h3);
    phase_tag = "R5";
    run_idle(200);
    phase_tag = "";

    wr(8'h10, 32'h8);
    run_idle(6);
    wr(8'h10, 32'h18);
    run_idle(40);

    for (int k = 0; k < 8; k++) wr(8'h0C, 32'd2);
    run_idle(20);

    wr(8'h20, 32'd5); wr(8'h24, 32'd5); wr(8'h28, 32'hD);
    wr(8'h04, 32'h7);
    for (int k = 0; k < 60; k++) begin
      cycle(1, 0, 8'((rot % 12) * 4), '0, (k % 3) == 0, (k % 7) == 3);
      rot++;
    end
    wr(8'h28, 32'hD);
    run_idle(12);
    wr(8'h2C, 32'h1234);
    run_idle(12);

    wr(8'h04, 32'h2);
    phase_tag = "R8";
    run_idle(40);
    phase_tag = "";

    cycle(1, 0, 8'h30, '0, 0, 0);
    wr(8'h34, 32'hFFFF);
    cycle(1, 0, 8'hFC, '0, 0, 0);
    wr(8'hF0, 32'h7);
    run_idle(12);

    wr(8'h00, 32'h1);
    run_idle(3);
    wr(8'h00, 32'hFE);
    run_idle(3);

    wr(8'h14, 32'd1); wr(8'h18, 32'd1); wr(8'h1C, 32'hC);
    phase_tag = "R5";
    run_idle(2200);
    phase_tag = "";

    two(0, 8'h00, '0, 1'b1, '0, "R11");
    two(0, 8'h20, '0, 1'b1, '0, "R11");
    two(1, 8'h04, 32'h4, 1'b1, '0, "R11");
    two(0, 8'h04, '0, 1'b0, '0, "R11");
    two(1, 8'h04, 32'h3, 1'b0, '0, "R3");
    two(0, 8'h04, '0, 1'b0, 32'h3, "R3");
    two(1, 8'h04, 32'h0, 1'b0, '0, "R3");
    two(1, 8'h10, 32'h5, 1'b1, '0, "R11");
    two(0, 8'h10, '0, 1'b0, '0, "R11");
    two(1, 8'h10, 32'h2, 1'b0, '0, "R7");
    two(0, 8'h10, '0, 1'b0, 32'h2, "R7");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule